// File: doc/BRIEF.md
# Q31 High-Word Multiply-Accumulate Unit

This unit is a lane-parallel fixed-point arithmetic stage. Each 32-bit lane multiplies two signed source elements into a full 64-bit signed product and keeps only the upper word of that product. The lane then adds that upper word to the matching signed 32-bit lane of an accumulator operand, or subtracts it from that lane. The sum or difference is clamped to the Q31 range.

A rounding select can round the upper word before the combine. In that mode, product bits 63:31 are treated as one 33-bit value, one is added to it, and bits 32:1 of the sum are kept. In effect this adds half of one unit of the upper word and truncates, so exact halves round toward plus infinity.

With the default 64-bit width the datapath holds two independent lanes. A 32-bit build holds one lane. A strobed input produces a registered result one clock later. Any lane that clamps sets a sticky overflow flag, and a dedicated input clears it.

Top module: `q31_hi_mac`

## Requirements
- R1: With rounding off and add mode, each lane's result is accumulator + (signed product of the sources >> 32), where the shift is arithmetic, whenever that value lies within the Q31 range.
- R2: With rounding on, the upper word is floor((product + 2^31) / 2^32). An exact half therefore goes upward: for example, a product of 2^31 gives 1 and a product of -2^31 gives 0.
- R3: With the subtract select high, each lane computes accumulator minus the selected upper word, and the same clamping rules apply.
- R4: A lane result above 2^31-1 is output as 0x7FFFFFFF.
- R5: A lane result below -2^31 is output as 0x80000000.
- R6: Lane 0 occupies bits 31:0 and lane 1 occupies bits 63:32 of every operand and of the result. Clamping in one lane does not change the other lane.
- R7: The overflow flag goes high in the cycle after an accepted input in which any lane clamps. It then stays high until it is cleared.
- R8: A high overflow-clear input makes the flag low in the next cycle, even when a clamping input is accepted in the same cycle.
- R9: The result and its valid strobe appear one clock after the input strobe. The result holds its value in cycles with no accepted input.
- R10: Synchronous active-high reset zeroes the result, the valid strobe and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands this cycle |
| acc_i | input | XLEN | Accumulator lanes |
| src_a_i | input | XLEN | First multiplicand lanes |
| src_b_i | input | XLEN | Second multiplicand lanes |
| sub_i | input | 1 | 1 = subtract the upper word, 0 = add it |
| round_i | input | 1 | 1 = round the upper word at bit 31 |
| ov_clr_i | input | 1 | Clear the sticky overflow flag |
| res_o | output | XLEN | Clamped lane results |
| res_valid_o | output | 1 | Result valid strobe |
| ov_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is the one where the rounding increment alone decides the result. This needs a product whose low 31 bits sit exactly on the half boundary, with both signs. It also includes the case where the rounding carry pushes an accumulator already at a Q31 limit into clamping. Directed operands are built as powers of two so that the product lands exactly on 2^31 or -2^31, and the two extreme products are combined with accumulators at both limits. Random operands with random add, subtract and rounding selects then fill the space between those corners, while clears are interleaved with clamping inputs.

// File: rtl/q31_hi_mac.sv
module q31_hi_mac #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic            sub_i,
  input  logic            round_i,
  input  logic            ov_clr_i,
  output logic [XLEN-1:0] res_o,
  output logic            res_valid_o,
  output logic            ov_o
);
  localparam int LW    = 32;
  localparam int LANES = XLEN / LW;
  localparam logic [LW-1:0] QMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] QMIN = {1'b1, {(LW-1){1'b0}}};

  logic [XLEN-1:0]  nxt;
  logic [LANES-1:0] sat;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0]          a_l, b_l, acc_l, hi;
    logic signed [2*LW-1:0] prod;
    logic [LW:0]            rnd_sum;
    logic signed [LW+1:0]   acc_x, hi_x, tot;
    logic                   clamp;

    assign a_l     = src_a_i[k*LW +: LW];
    assign b_l     = src_b_i[k*LW +: LW];
    assign acc_l   = acc_i[k*LW +: LW];
    assign prod    = $signed(a_l) * $signed(b_l);
    assign rnd_sum = prod[2*LW-1:LW-1] + {{LW{1'b0}}, 1'b1};
    assign hi      = round_i ? rnd_sum[LW:1] : prod[2*LW-1:LW];
    assign acc_x   = {{2{acc_l[LW-1]}}, acc_l};
    assign hi_x    = {{2{hi[LW-1]}}, hi};
    assign tot     = sub_i ? acc_x - hi_x : acc_x + hi_x;
    assign clamp   = (tot[LW+1:LW-1] != 3'b000) && (tot[LW+1:LW-1] != 3'b111);
    assign sat[k]  = clamp;
    assign nxt[k*LW +: LW] = clamp ? (tot[LW+1] ? QMIN : QMAX) : tot[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= in_valid;
      if (in_valid) res_o <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  ov_o <= 1'b0;
    else if (ov_clr_i)        ov_o <= 1'b0;
    else if (in_valid && |sat) ov_o <= 1'b1;
  end

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !res_valid_o && !ov_o));
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (res_valid_o == $past(in_valid)));
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_o));
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (in_valid && |sat && !ov_clr_i) |=> ov_o);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ov_o && !ov_clr_i) |=> ov_o);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ov_clr_i |=> !ov_o);
endmodule

// File: tb/q31_hi_mac_tb.sv
module q31_hi_mac_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, sub_i = 1'b0, round_i = 1'b0, ov_clr_i = 1'b0;
  logic [XLEN-1:0] acc_i = '0, src_a_i = '0, src_b_i = '0;
  logic [XLEN-1:0] res_o;
  logic res_valid_o, ov_o;

  int checks = 0, errors = 0;
  logic [63:0] exp_res = '0;
  bit exp_ov = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  q31_hi_mac #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_i(acc_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .sub_i(sub_i), .round_i(round_i),
    .ov_clr_i(ov_clr_i), .res_o(res_o), .res_valid_o(res_valid_o), .ov_o(ov_o)
  );

  function automatic logic [32:0] ref_lane(logic [31:0] acc, logic [31:0] a,
                                           logic [31:0] b, bit sub, bit rnd);
    longint p, hi, r;
    p  = longint'($signed(a)) * longint'($signed(b));
    hi = rnd ? ((p + 64'sd2147483648) >>> 32) : (p >>> 32);
    r  = sub ? longint'($signed(acc)) - hi : longint'($signed(acc)) + hi;
    if (r > 64'sd2147483647)       return {1'b1, 32'h7FFFFFFF};
    else if (r < -64'sd2147483648) return {1'b1, 32'h80000000};
    else                           return {1'b0, r[31:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(string req, logic [63:0] acc, logic [63:0] a, logic [63:0] b,
                    bit sub, bit rnd, bit clr);
    logic [32:0] l0, l1;
    @(negedge clk);
    acc_i = acc; src_a_i = a; src_b_i = b; sub_i = sub; round_i = rnd;
    ov_clr_i = clr; in_valid = 1'b1;
    l0 = ref_lane(acc[31:0], a[31:0], b[31:0], sub, rnd);
    l1 = ref_lane(acc[63:32], a[63:32], b[63:32], sub, rnd);
    exp_res = {l1[31:0], l0[31:0]};
    if (clr) exp_ov = 1'b0;
    else if (l0[32] || l1[32]) exp_ov = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; ov_clr_i = 1'b0;
    chk(req, res_o, exp_res);
    chk({req, " valid R9"}, {63'd0, res_valid_o}, 64'd1);
    chk({req, " flag R7"}, {63'd0, ov_o}, {63'd0, exp_ov});
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R10 reset result", res_o, '0);
    chk("R10 reset valid", {63'd0, res_valid_o}, 64'd0);
    chk("R10 reset flag", {63'd0, ov_o}, 64'd0);
    rst = 1'b0;

    // R1 extreme negative times negative: 2^62 >> 32 = 0x40000000
    op("R1 min*min", 64'h0, 64'h80000000_80000000, 64'h80000000_80000000, 0, 0, 0);
    chk("R1 min*min value", res_o, 64'h40000000_40000000);
    op("R2 max*max round", 64'h0, 64'h7FFFFFFF_7FFFFFFF, 64'h7FFFFFFF_7FFFFFFF, 0, 1, 0);
    // R2 tie cases: lane0 product 2^31, lane1 product -2^31
    op("R2 tie round", 64'h0, 64'hFFFF0000_00010000, 64'h00008000_00008000, 0, 1, 0);
    chk("R2 tie value", res_o, 64'h00000000_00000001);
    op("R1 tie trunc", 64'h0, 64'hFFFF0000_00010000, 64'h00008000_00008000, 0, 0, 0);
    chk("R1 tie trunc value", res_o, 64'hFFFFFFFF_00000000);
    // R4 rounding carry pushes top-limit accumulator over
    op("R4 round carry clamp", 64'h00000000_7FFFFFFF, 64'h0_00010000, 64'h0_00008000, 0, 1, 0);
    chk("R4 clamp value", res_o[31:0], 64'h7FFFFFFF);
    chk("R7 flag after clamp", {63'd0, ov_o}, 64'd1);
    op("R7 sticky", 64'h0, 64'h2, 64'h3, 0, 0, 0);
    chk("R7 still set", {63'd0, ov_o}, 64'd1);
    op("R8 clear only", 64'h0, 64'h2, 64'h3, 0, 0, 1);
    chk("R8 cleared", {63'd0, ov_o}, 64'd0);
    // R5/R3 subtract from bottom limit
    op("R5 sub clamp", 64'h80000000_00000000, 64'h40000000_40000000,
       64'h40000000_40000000, 1, 0, 0);
    chk("R5 value", res_o, 64'h80000000_F0000000);
    chk("R6 lane0 untouched", res_o[31:0], 64'hF0000000);
    op("R8 clear beats set", 64'h7FFFFFFF_7FFFFFFF, 64'h7FFFFFFF_7FFFFFFF,
       64'h7FFFFFFF_7FFFFFFF, 0, 0, 1);
    chk("R8 flag low", {63'd0, ov_o}, 64'd0);
    op("R3 sub plain", 64'h00000010_00000010, 64'h00020000_FFFE0000,
       64'h00030000_00030000, 1, 0, 0);
    // R9 hold through idle cycles
    repeat (2) @(negedge clk);
    chk("R9 hold result", res_o, exp_res);
    chk("R9 idle valid", {63'd0, res_valid_o}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb, rc;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rc = {$urandom, $urandom};
      if (i % 7 == 0) ra[31:0] = 32'h80000000;
      if (i % 5 == 0) rc[63:32] = (i % 2) ? 32'h7FFFFFFF : 32'h80000000;
      op("R1 R2 R3 R6 random", rc, ra, rb, $urandom % 2, $urandom % 2,
         ($urandom % 9) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule